// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel whose work list lives in memory. Software places one or more control blocks in memory. Each block is eight 32-bit words, and the channel reads the first six of them: an info word, the source address, the destination address, the byte length, a stride word and the address of the next block. The last two words are padding. Software then writes the address of the first block to the channel and sets the run bit. The channel loads the block and copies the data one 32-bit word at a time, reading from the source and then writing to the destination. Each address either advances by four after each word or stays fixed, as the info word selects.

When a block is finished, the channel loads the block at the next-block address. A next-block address of zero stops the channel. A chain whose last block points back to its first runs for ever, which suits circular audio buffers. A peripheral request line can pace the reads, the writes, or both, and each block selects the line and the paced side. Software can pause the channel by clearing the run bit. It can skip the rest of the current block, reset the channel, and edit the next-block pointer while the channel is paused. A block can raise a level interrupt when it ends. A memory error response stops the channel.

Top module: `lcbd_chan`

## Requirements
- R1: Writing a block address to offset 0x04 and then writing 1 to bit 0 (run) of offset 0x00 makes the channel read the six words at that address and the five addresses after it in steps of 4, in that order. The words are info, source, destination, length, stride and next-block.
- R2: Once raised, `mem_req` stays high with a stable `mem_addr` and `mem_we` until the cycle `mem_ack` is seen.
- R3: The channel copies length/4 words, each a read of the source and then a write of the destination. Info bit 8 set advances the source by 4 per word and info bit 4 does the same for the destination. When a bit is clear, that address stays fixed.
- R4: At the end of a block whose info bit 0 is 1, status bit 2 and `irq` go high. Writing 1 to bit 2 of offset 0x00 clears them, and writing 0 there leaves them set.
- R5: Info bit 10 paces the reads and info bit 6 paces the writes, using the line picked by the select field at info bits [19:16]. While that line is low, the paced access is not issued and status bit 5 reads 1. A select value of 0 always lets the access proceed.
- R6: When a block ends, the channel loads the block named by its next-block word, and that address shows at offset 0x04. A next-block word of 0 clears the run bit. A block that points back to itself repeats without end.
- R7: Writing 0 to offset 0x00 stops the channel once any access already in flight has been acknowledged. Status bit 4 reads 1 when the run bit is clear and no access is outstanding. Setting the run bit again resumes the work where it stopped.
- R8: Offset 0x1C shows the next-block pointer loaded from the current block. A value written there while the channel is paused is the one used when the block ends.
- R9: Writing 1 to bit 30 of offset 0x00 ends the current block with no further copying and no interrupt from that block, and the channel moves on to its next block.
- R10: A response with `mem_err` high sets status bit 8, clears the run bit and stops all further memory requests.
- R11: Writing 1 to bit 31 of offset 0x00 returns the channel to its reset state: run, interrupt and error cleared, all addresses 0. The bit itself reads back as 0.
- R12: Offsets 0x0C and 0x10 show the current source and destination addresses. Every other offset reads 0.
- R13: After reset, offset 0x00 reads 0x10, `irq` and `mem_req` are low, and offsets 0x04 and 0x1C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_err | input | 1 | Error response, valid together with `mem_ack` |
| mem_rdata | input | 32 | Memory read data |
| dreq_in | input | NUM_DREQ | Peripheral request lines |
| irq | output | 1 | Interrupt, high while the interrupt flag is set |

## Verification
The hardest state to reach is a block that has been left unfinished. In that state the channel has loaded a block, copied part of it and is waiting, and software then pauses it, rewrites its next pointer or aborts it. The bench reaches this state by pacing writes on a request line and dropping that line, so the channel stops in front of a write and flags that it is held. The pause, the pointer rewrite and the abort each happen at that point, and the bench then observes whether the destination words were written and where the chain goes. A memory error is injected at one chosen source address, so that the stop happens in the middle of a block.

// File: rtl/lcbd_pkg.sv
package lcbd_pkg;
   localparam int DATA_W    = 32;
   localparam int WORD_B    = DATA_W / 8;
   localparam int FETCH_N   = 6;

   // register byte offsets
   localparam int OFS_CS    = 'h00;
   localparam int OFS_CBA   = 'h04;
   localparam int OFS_SRC   = 'h0C;
   localparam int OFS_DST   = 'h10;
   localparam int OFS_NXT   = 'h1C;

   // control/status bit positions
   localparam int CS_RUN    = 0;
   localparam int CS_INT    = 2;
   localparam int CS_IDLE   = 4;
   localparam int CS_HELD   = 5;
   localparam int CS_ERR    = 8;
   localparam int CS_SKIP   = 30;
   localparam int CS_CLR    = 31;

   // info word bit positions
   localparam int TI_IRQ    = 0;
   localparam int TI_DINC   = 4;
   localparam int TI_DPACE  = 6;
   localparam int TI_SINC   = 8;
   localparam int TI_SPACE  = 10;
   localparam int TI_SEL    = 16;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_END
   } lcbd_state_e;

   typedef struct packed {
      logic irq_en;
      logic src_inc;
      logic dst_inc;
      logic src_pace;
      logic dst_pace;
   } lcbd_info_t;
endpackage

// File: rtl/lcbd_pacer.sv
module lcbd_pacer #(
   parameter int NUM_DREQ = 16,
   parameter int SEL_W    = 4
) (
   input  logic [NUM_DREQ-1:0] dreq,
   input  logic [SEL_W-1:0]    sel,
   output logic                permit
);
   localparam int SPAN = 1 << SEL_W;

   logic [SPAN-1:0] line_ok;

   for (genvar i = 0; i < SPAN; i++) begin : g_line
      if (i < NUM_DREQ) begin : g_real
         assign line_ok[i] = dreq[i];
      end else begin : g_none
         assign line_ok[i] = 1'b0;
      end
   end

   // select 0 means unpaced: always permitted
   assign permit = (sel == '0) | line_ok[sel];
endmodule

// File: rtl/lcbd_csr_mux.sv
module lcbd_csr_mux
   import lcbd_pkg::*;
#(
   parameter int REG_AW = 8
) (
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       status,
   input  logic [31:0]       cba,
   input  logic [31:0]       src,
   input  logic [31:0]       dst,
   input  logic [31:0]       nxt,
   output logic [31:0]       rdata
);
   always_comb begin
      case (addr)
         REG_AW'(OFS_CS):  rdata = status;
         REG_AW'(OFS_CBA): rdata = cba;
         REG_AW'(OFS_SRC): rdata = src;
         REG_AW'(OFS_DST): rdata = dst;
         REG_AW'(OFS_NXT): rdata = nxt;
         default:          rdata = '0;
      endcase
   end
endmodule

// File: rtl/lcbd_chan.sv
module lcbd_chan
   import lcbd_pkg::*;
#(
   parameter int NUM_DREQ = 16,
   parameter int REG_AW   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wen,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [31:0]         mem_addr,
   output logic [31:0]         mem_wdata,
   input  logic                mem_ack,
   input  logic                mem_err,
   input  logic [31:0]         mem_rdata,
   input  logic [NUM_DREQ-1:0] dreq_in,
   output logic                irq
);
   localparam int          SEL_W    = (NUM_DREQ > 1) ? $clog2(NUM_DREQ) : 1;
   localparam logic [31:0] STEP     = 32'(WORD_B);
   localparam logic [2:0]  LAST_IDX = 3'(FETCH_N - 1);

   if (NUM_DREQ < 2 || SEL_W > 16) begin : g_bad_dreq
      $error("lcbd_chan: NUM_DREQ must give a select field of 1..16 bits");
   end
   if (REG_AW < 5) begin : g_bad_aw
      $error("lcbd_chan: REG_AW too small for the register map");
   end

   lcbd_state_e      state_q;
   logic [2:0]       idx_q;
   logic             act_q, int_q, err_q, skip_q, req_q;
   logic [31:0]      cba_q, src_q, dst_q, len_q, nxt_q, data_q;
   lcbd_info_t       info_q;
   logic [SEL_W-1:0] sel_q;

   logic go, permit, pace_ok, xfer_st, issue, done, held;
   logic cs_wr, soft_clr;
   logic [31:0] status;

   assign cs_wr    = reg_wen && (reg_addr == REG_AW'(OFS_CS));
   assign soft_clr = cs_wr && reg_wdata[CS_CLR];
   assign go       = act_q && !err_q;
   assign xfer_st  = (state_q == ST_READ) || (state_q == ST_WRITE);

   lcbd_pacer #(.NUM_DREQ(NUM_DREQ), .SEL_W(SEL_W)) u_pacer (
      .dreq(dreq_in), .sel(sel_q), .permit(permit)
   );

   always_comb begin
      case (state_q)
         ST_READ:  pace_ok = !info_q.src_pace || permit;
         ST_WRITE: pace_ok = !info_q.dst_pace || permit;
         default:  pace_ok = 1'b1;
      endcase
   end

   assign issue = go && !req_q && pace_ok &&
                  ((state_q == ST_FETCH) || (xfer_st && !skip_q));
   assign done  = req_q && mem_ack;
   assign held  = go && !req_q && xfer_st && !pace_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;  idx_q  <= '0;  act_q <= 1'b0;  int_q <= 1'b0;
         err_q   <= 1'b0;     skip_q <= 1'b0; req_q <= 1'b0;
         cba_q   <= '0;  src_q <= '0;  dst_q <= '0;  len_q <= '0;
         nxt_q   <= '0;  data_q <= '0; info_q <= '0; sel_q <= '0;
      end else if (soft_clr) begin
         state_q <= ST_IDLE;  idx_q  <= '0;  act_q <= 1'b0;  int_q <= 1'b0;
         err_q   <= 1'b0;     skip_q <= 1'b0; req_q <= 1'b0;
         cba_q   <= '0;  src_q <= '0;  dst_q <= '0;  len_q <= '0;
         nxt_q   <= '0;  data_q <= '0; info_q <= '0; sel_q <= '0;
      end else begin
         // software writes first; block-end events below take precedence
         if (cs_wr) begin
            act_q <= reg_wdata[CS_RUN];
            if (reg_wdata[CS_INT]) int_q <= 1'b0;
            if (reg_wdata[CS_SKIP] && state_q != ST_IDLE) skip_q <= 1'b1;
         end
         if (reg_wen && reg_addr == REG_AW'(OFS_CBA)) cba_q <= reg_wdata;
         if (reg_wen && reg_addr == REG_AW'(OFS_NXT)) nxt_q <= reg_wdata;

         if (issue) req_q <= 1'b1;
         if (done)  req_q <= 1'b0;

         if (done && mem_err) begin
            err_q   <= 1'b1;
            act_q   <= 1'b0;
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  skip_q <= 1'b0;
                  if (go) begin
                     state_q <= ST_FETCH;
                     idx_q   <= '0;
                  end
               end
               ST_FETCH: if (done) begin
                  case (idx_q)
                     3'd0: begin
                        info_q.irq_en   <= mem_rdata[TI_IRQ];
                        info_q.src_inc  <= mem_rdata[TI_SINC];
                        info_q.dst_inc  <= mem_rdata[TI_DINC];
                        info_q.src_pace <= mem_rdata[TI_SPACE];
                        info_q.dst_pace <= mem_rdata[TI_DPACE];
                        sel_q           <= mem_rdata[TI_SEL +: SEL_W];
                     end
                     3'd1:    src_q <= mem_rdata;
                     3'd2:    dst_q <= mem_rdata;
                     3'd3:    len_q <= mem_rdata;
                     3'd5:    nxt_q <= mem_rdata;
                     default: ;
                  endcase
                  idx_q <= idx_q + 3'd1;
                  if (idx_q == LAST_IDX)
                     state_q <= (len_q == '0) ? ST_END : ST_READ;
               end
               ST_READ: begin
                  if (skip_q && !req_q) begin
                     state_q <= ST_END;
                  end else if (done) begin
                     data_q  <= mem_rdata;
                     if (info_q.src_inc) src_q <= src_q + STEP;
                     state_q <= ST_WRITE;
                  end
               end
               ST_WRITE: begin
                  if (skip_q && !req_q) begin
                     state_q <= ST_END;
                  end else if (done) begin
                     if (info_q.dst_inc) dst_q <= dst_q + STEP;
                     if (len_q <= STEP) begin
                        len_q   <= '0;
                        state_q <= ST_END;
                     end else begin
                        len_q   <= len_q - STEP;
                        state_q <= ST_READ;
                     end
                  end
               end
               ST_END: begin
                  if (info_q.irq_en && !skip_q) int_q <= 1'b1;
                  skip_q <= 1'b0;
                  idx_q  <= '0;
                  if (nxt_q == '0) begin
                     act_q   <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     cba_q   <= nxt_q;
                     state_q <= ST_FETCH;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      mem_addr = '0;
      case (state_q)
         ST_FETCH: mem_addr = cba_q + {27'd0, idx_q, 2'b00};
         ST_READ:  mem_addr = src_q;
         ST_WRITE: mem_addr = dst_q;
         default:  mem_addr = '0;
      endcase
   end

   assign mem_req   = req_q;
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_wdata = data_q;
   assign irq       = int_q;

   always_comb begin
      status          = '0;
      status[CS_RUN]  = act_q;
      status[CS_INT]  = int_q;
      status[CS_IDLE] = !act_q && !req_q;
      status[CS_HELD] = held;
      status[CS_ERR]  = err_q;
   end

   lcbd_csr_mux #(.REG_AW(REG_AW)) u_csr (
      .addr(reg_addr), .status(status), .cba(cba_q), .src(src_q),
      .dst(dst_q), .nxt(nxt_q), .rdata(reg_rdata)
   );
endmodule

// File: rtl/lcbd_chan_chk.sv
module lcbd_chan_chk
   import lcbd_pkg::*;
#(
   parameter int NUM_DREQ = 16,
   parameter int SEL_W    = 4,
   parameter int REG_AW   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wen,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic                mem_req,
   input logic                mem_we,
   input logic [31:0]         mem_addr,
   input logic                mem_ack,
   input logic                mem_err,
   input logic [NUM_DREQ-1:0] dreq_in,
   input logic                irq,
   input logic                act_q,
   input lcbd_state_e         state_q,
   input lcbd_info_t          info_q,
   input logic [SEL_W-1:0]    sel_q
);
   logic sel_ok, paced_now, cs_write;

   always_comb begin
      sel_ok = (sel_q == '0);
      for (int i = 0; i < NUM_DREQ; i++)
         if (int'(sel_q) == i && dreq_in[i]) sel_ok = 1'b1;
   end

   assign paced_now = (state_q == ST_READ  && info_q.src_pace) ||
                      (state_q == ST_WRITE && info_q.dst_pace);
   assign cs_write  = reg_wen && reg_addr == REG_AW'(OFS_CS);

   // R2: request held with stable address and direction until acknowledged
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R5: a paced access starts only if its selected line permitted it
   a_r5_paced_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && paced_now |-> $past(sel_ok));

   // R7: no new access while the run bit is clear
   a_r7_no_access_paused: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q && !mem_req |=> !mem_req);

   // R10: error response stops the channel
   a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_err && !reg_wen |=> !mem_req && !act_q);

   // R11: soft reset clears run, interrupt and request
   a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cs_write && reg_wdata[CS_CLR] |=> !irq && !act_q && !mem_req);

   // R4: write-one clear drops the interrupt
   a_r4_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cs_write && reg_wdata[CS_INT] && state_q != ST_END |=> !irq);

   // R4: interrupt rises only right after a block end
   a_r4_int_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(state_q == ST_END));
endmodule

bind lcbd_chan lcbd_chan_chk #(
   .NUM_DREQ(NUM_DREQ), .SEL_W(SEL_W), .REG_AW(REG_AW)
) u_lcbd_chk (
   .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
   .dreq_in(dreq_in), .irq(irq), .act_q(act_q), .state_q(state_q),
   .info_q(info_q), .sel_q(sel_q)
);

// File: tb/test_lcbd_chan.sv
`timescale 1ns/1ps
module test_lcbd_chan;
   localparam int NDQ = 16;
   localparam int AW  = 8;

   localparam logic [31:0] I_IRQ = 32'h1,   I_DINC = 32'h10, I_DPACE = 32'h40;
   localparam logic [31:0] I_SINC = 32'h100, I_SPACE = 32'h400;

   localparam int NVEC = 4;
   localparam logic [31:0] VEC_INFO [NVEC] = '{32'h110, 32'h100, 32'h010, 32'h111};
   localparam int          VEC_N    [NVEC] = '{4, 3, 3, 1};

   logic clk = 0, rst_n = 0;
   logic reg_wen = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [NDQ-1:0] dreq_in = '0;
   logic irq;

   always #2.5 clk = ~clk;

   lcbd_chan #(.NUM_DREQ(NDQ), .REG_AW(AW)) i_lcbd_chan (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .dreq_in(dreq_in), .irq(irq)
   );

   // memory model, host poke port, access log, hold monitor
   logic [31:0] mem [0:255];
   logic host_we = 0;
   logic [31:0] host_a = '0, host_d = '0;
   logic err_en = 0;
   logic [31:0] err_addr = '0;
   logic [31:0] rd_log [0:15];
   int rd_cnt = 0, wr_cnt = 0, hold_bad = 0;
   logic prev_pend = 0;
   logic [31:0] prev_addr = '0;

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (host_we) mem[host_a[9:2]] <= host_d;
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_bad++;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         mem_err <= err_en && (mem_addr == err_addr);
         if (mem_we) begin
            if (!(err_en && mem_addr == err_addr)) mem[mem_addr[9:2]] <= mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata <= mem[mem_addr[9:2]];
            rd_log[rd_cnt % 16] <= mem_addr;
            rd_cnt++;
         end
      end
   end

   int n_chk = 0, n_err = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); host_we = 1; host_a = a; host_d = d;
      @(negedge clk); host_we = 0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_wen = 1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk); reg_wen = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); reg_addr = AW'(a); #1; d = reg_rdata;
   endtask

   task automatic put_cb(input logic [31:0] base, info, src, dst, len, nxt);
      poke(base, info); poke(base + 4, src); poke(base + 8, dst);
      poke(base + 12, len); poke(base + 16, 0); poke(base + 20, nxt);
   endtask

   task automatic wait_stop();
      logic [31:0] s;
      for (int k = 0; k < 3000; k++) begin
         rd('h00, s);
         if (!s[0]) break;
      end
   endtask

   task automatic wait_irq();
      for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
   endtask

   function automatic logic [31:0] pat(input int v, input int i);
      return 32'hA500_0000 | (v << 8) | i;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] s, e;
      int r0, w0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R13: reset state
      rd('h00, s); chk("R13 status", s, 32'h10);
      chk("R13 irq", {31'd0, irq}, 0);
      chk("R13 mem_req", {31'd0, mem_req}, 0);
      rd('h04, s); chk("R13 cba", s, 0);
      rd('h1C, s); chk("R13 next", s, 0);

      // R3 / R1 / R12: table of single-block copies
      for (int v = 0; v < NVEC; v++) begin
         for (int i = 0; i < 4; i++) begin
            poke(32'h100 + 4 * i, pat(v, i));
            poke(32'h200 + 4 * i, 0);
         end
         put_cb(0, VEC_INFO[v], 32'h100, 32'h200, VEC_N[v] * 4, 0);
         r0 = rd_cnt;
         wr('h04, 0);
         wr('h00, 1);
         wait_stop();
         for (int i = 0; i < 4; i++) begin
            if (VEC_INFO[v][4])
               e = (i < VEC_N[v]) ? (VEC_INFO[v][8] ? pat(v, i) : pat(v, 0)) : 0;
            else
               e = (i == 0) ? (VEC_INFO[v][8] ? pat(v, VEC_N[v] - 1) : pat(v, 0)) : 0;
            chk($sformatf("R3 vec%0d dst%0d", v, i), mem[128 + i], e);
         end
         rd('h0C, s); chk("R12 src reg", s, 32'h100 + (VEC_INFO[v][8] ? 4 * VEC_N[v] : 0));
         rd('h10, s); chk("R12 dst reg", s, 32'h200 + (VEC_INFO[v][4] ? 4 * VEC_N[v] : 0));
         chk("R4 irq per info bit0", {31'd0, irq}, {31'd0, VEC_INFO[v][0]});
         if (v == 0)
            for (int k = 0; k < 6; k++)
               chk("R1 fetch order", rd_log[(r0 + k) % 16], 32'(4 * k));
         if (irq) begin
            wr('h00, 0); chk("R4 write 0 keeps irq", {31'd0, irq}, 1);
            wr('h00, 4); chk("R4 w1c clears irq", {31'd0, irq}, 0);
         end
      end
      rd('h08, s); chk("R12 unmapped", s, 0);

      // R5: paced reads, line 3 low then high
      poke(32'h100, 32'h11); poke(32'h104, 32'h22);
      poke(32'h220, 0); poke(32'h224, 0);
      put_cb(0, I_SPACE | I_SINC | I_DINC | (32'd3 << 16), 32'h100, 32'h220, 8, 0);
      dreq_in = '0;
      w0 = wr_cnt;
      wr('h04, 0); wr('h00, 1);
      repeat (40) @(negedge clk);
      rd('h00, s); chk("R5 held bit", {31'd0, s[5]}, 1);
      chk("R5 no write while held", 32'(wr_cnt - w0), 0);
      dreq_in[3] = 1'b1;
      wait_stop();
      chk("R5 copy after line high", mem[(32'h224) >> 2], 32'h22);
      // R5: select 0 never waits
      dreq_in = '0;
      poke(32'h228, 0);
      put_cb(0, I_SPACE | I_SINC | I_DINC, 32'h104, 32'h228, 4, 0);
      wr('h00, 1);
      wait_stop();
      chk("R5 select 0 proceeds", mem[(32'h228) >> 2], 32'h22);

      // R6: two-block chain
      poke(32'h100, 32'h31); poke(32'h104, 32'h32);
      put_cb(0, I_SINC | I_DINC, 32'h100, 32'h240, 4, 32'h20);
      put_cb(32'h20, I_SINC | I_DINC, 32'h104, 32'h244, 4, 0);
      wr('h04, 0); wr('h00, 1);
      wait_stop();
      chk("R6 chain block0", mem[(32'h240) >> 2], 32'h31);
      chk("R6 chain block1", mem[(32'h244) >> 2], 32'h32);
      rd('h04, s); chk("R6 cba follows chain", s, 32'h20);

      // R6 cyclic, then R5 hold, R7 pause, R8 next-pointer edit
      dreq_in = 16'h0004;
      put_cb(32'h40, I_IRQ | I_SINC | I_DINC | I_DPACE | (32'd2 << 16),
             32'h110, 32'h260, 8, 32'h40);
      wr('h04, 32'h40); wr('h00, 1);
      wait_irq();
      chk("R6 first lap irq", {31'd0, irq}, 1);
      wr('h00, 5);
      wait_irq();
      chk("R6 second lap irq", {31'd0, irq}, 1);
      rd('h00, s); chk("R6 still running", {31'd0, s[0]}, 1);
      rd('h04, s); chk("R6 cyclic cba", s, 32'h40);
      dreq_in = '0;
      repeat (50) @(negedge clk);
      rd('h00, s); chk("R5 held on write pace", {31'd0, s[5]}, 1);
      wr('h00, 0);
      repeat (5) @(negedge clk);
      rd('h00, s); chk("R7 paused status", s & 32'h11, 32'h10);
      wr('h1C, 0);
      rd('h1C, s); chk("R8 next readback", s, 0);
      dreq_in = 16'h0004;
      w0 = wr_cnt;
      repeat (30) @(negedge clk);
      chk("R7 no access while paused", 32'(wr_cnt - w0), 0);
      wr('h00, 1);
      wait_stop();
      rd('h00, s); chk("R8 edited next ends chain", {31'd0, s[0]}, 0);
      chk("R7 resumed and wrote", {31'd0, wr_cnt > w0}, 1);
      wr('h00, 4);

      // R9: abort a held block, continue with its successor
      dreq_in = '0;
      poke(32'h100, 32'h41); poke(32'h104, 32'h42);
      poke(32'h280, 0); poke(32'h284, 0);
      put_cb(0, I_IRQ | I_SINC | I_DINC | I_DPACE | (32'd5 << 16), 32'h100, 32'h280, 4, 32'h20);
      put_cb(32'h20, I_SINC | I_DINC, 32'h104, 32'h284, 4, 0);
      wr('h04, 0); wr('h00, 1);
      repeat (40) @(negedge clk);
      wr('h00, 32'h4000_0001);
      wait_stop();
      chk("R9 aborted block not written", mem[(32'h280) >> 2], 0);
      chk("R9 next block ran", mem[(32'h284) >> 2], 32'h42);
      chk("R9 no irq from aborted block", {31'd0, irq}, 0);

      // R10: error on third source word
      poke(32'h100, 32'h51); poke(32'h104, 32'h52); poke(32'h108, 32'h53);
      poke(32'h2A0, 0); poke(32'h2A4, 0); poke(32'h2A8, 0);
      put_cb(0, I_SINC | I_DINC, 32'h100, 32'h2A0, 12, 0);
      err_addr = 32'h108; err_en = 1;
      wr('h04, 0); wr('h00, 1);
      repeat (80) @(negedge clk);
      rd('h00, s); chk("R10 error bit and stopped", s & 32'h101, 32'h100);
      chk("R10 no request", {31'd0, mem_req}, 0);
      chk("R10 earlier word copied", mem[(32'h2A4) >> 2], 32'h52);
      chk("R10 later word untouched", mem[(32'h2A8) >> 2], 0);
      err_en = 0;

      // R11: soft reset
      wr('h00, 32'h8000_0000);
      rd('h00, s); chk("R11 status cleared", s, 32'h10);
      rd('h04, s); chk("R11 cba cleared", s, 0);
      rd('h0C, s); chk("R11 src cleared", s, 0);
      chk("R11 irq low", {31'd0, irq}, 0);

      chk("R2 request hold violations", 32'(hold_bad), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule